// File: doc/BRIEF.md
# Programmable User Sync Generator

This block derives one user-defined timing strobe from the raster position of a video pipeline. It watches the current pixel position within a line, the current line within a field and a field flag. It builds two windows from these: a horizontal one spanning a range of pixels and a vertical one spanning a range of lines. It merges them with a selectable logic operator and drives the result at a programmable polarity. Typical uses are custom blanking gates, trigger pulses or region markers for downstream logic.

Configuration arrives through a narrow write-only port. Writes land in a pending copy of the settings. That copy becomes live only at the start of a line, so a line is never drawn with half-old, half-new settings. The strobe is registered and lags the counter inputs by one pixel clock.

Top module: `usync_gen`

## Requirements
- R1: While reset is asserted and after its release, before any write, the output is 1: polarity is active-low, both windows are empty (all bounds 0) and no operator is selected.
- R2: The horizontal window is active when hstart <= pix_cnt < hstop. Both bounds are 16 bits. Address 0 holds hstart and address 1 holds hstop, taken from wr_data[15:0].
- R3: The vertical window is active when vstart <= line_cnt < vstop and field_id is 0 (odd field). With field_id at 1 it is inactive. Address 2 holds vstart and address 3 holds vstop, taken from wr_data[14:0].
- R4: A window whose start is greater than or equal to its stop is never active.
- R5: With control bit 2 (AND) set, the merged signal is H AND V, and bits 1 and 0 have no effect.
- R6: With bit 2 clear and bit 1 (OR) set, the merged signal is H OR V, and bit 0 has no effect.
- R7: With only bit 0 (XOR) set among the operator bits, the merged signal is active when exactly one window is active.
- R8: With no operator bit set, the merged signal is inactive.
- R9: Control bit 3 selects polarity. At 1 the output is the inverse of the merged signal (active-low). At 0 the output equals the merged signal. The control register is address 4.
- R10: The output is registered. The value seen after a clock edge reflects the counters sampled at that edge.
- R11: Writes take effect at the next edge where pix_cnt is 0. That edge's output already uses them, and a write made in that same cycle waits for the following line start.
- R12: Bit 15 of the vertical bounds and bits 15..4 of the control word are discarded. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_cnt | input | 16 | Pixel position in the current line |
| line_cnt | input | 15 | Line position in the current field |
| field_id | input | 1 | 0 = odd field, 1 = even field |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| usync_o | output | 1 | Registered user sync output |

## Verification
The bench builds the block with its default widths and the odd-field-only vertical qualifier. It drives a short 24-pixel by 10-line raster whose field flag alternates, so every field boundary, window edge and operator change recurs many times within a few thousand cycles. Every operator code from 0 to 7 is run at both polarities, which covers the priority cases. Inverted and zero-width windows, writes with reserved bits set, stray addresses, and a series of mid-line bound updates exercise the deferred-commit timing against the behavioural model.

// File: rtl/usync_pkg.sv
package usync_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] A_HSTART = 3'd0;
  localparam logic [REG_AW-1:0] A_HSTOP  = 3'd1;
  localparam logic [REG_AW-1:0] A_VSTART = 3'd2;
  localparam logic [REG_AW-1:0] A_VSTOP  = 3'd3;
  localparam logic [REG_AW-1:0] A_CTRL   = 3'd4;

  // Field order follows the control word bit positions 3..0.
  typedef struct packed {
    logic pol_inv;
    logic op_and;
    logic op_or;
    logic op_xor;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{pol_inv: 1'b1, op_and: 1'b0, op_or: 1'b0, op_xor: 1'b0};
endpackage

// File: rtl/usync_regs.sv
module usync_regs
  import usync_pkg::*;
#(
  parameter int PIX_W  = 16,
  parameter int LINE_W = 15,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_start,
  output logic [PIX_W-1:0]  cur_hs,
  output logic [PIX_W-1:0]  cur_he,
  output logic [LINE_W-1:0] cur_vs,
  output logic [LINE_W-1:0] cur_ve,
  output ctrl_t             cur_ctrl,
  output logic [PIX_W-1:0]  act_hs,
  output logic [PIX_W-1:0]  act_he,
  output ctrl_t             act_ctrl
);
  logic [PIX_W-1:0]  pnd_hs, pnd_he, pnd_hs_n, pnd_he_n;
  logic [LINE_W-1:0] pnd_vs, pnd_ve, pnd_vs_n, pnd_ve_n;
  ctrl_t             pnd_ctrl, pnd_ctrl_n;
  logic [LINE_W-1:0] lv_vs, lv_ve;

  // pending copy: next-state
  always_comb begin
    pnd_hs_n   = pnd_hs;
    pnd_he_n   = pnd_he;
    pnd_vs_n   = pnd_vs;
    pnd_ve_n   = pnd_ve;
    pnd_ctrl_n = pnd_ctrl;
    if (wr_en) begin
      case (wr_addr)
        A_HSTART: pnd_hs_n   = wr_data[PIX_W-1:0];
        A_HSTOP:  pnd_he_n   = wr_data[PIX_W-1:0];
        A_VSTART: pnd_vs_n   = wr_data[LINE_W-1:0];
        A_VSTOP:  pnd_ve_n   = wr_data[LINE_W-1:0];
        A_CTRL:   pnd_ctrl_n = ctrl_t'(wr_data[3:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pnd_hs   <= '0;
      pnd_he   <= '0;
      pnd_vs   <= '0;
      pnd_ve   <= '0;
      pnd_ctrl <= CTRL_RST;
    end else begin
      pnd_hs   <= pnd_hs_n;
      pnd_he   <= pnd_he_n;
      pnd_vs   <= pnd_vs_n;
      pnd_ve   <= pnd_ve_n;
      pnd_ctrl <= pnd_ctrl_n;
    end
  end

  // live copy: settings in force for this cycle's counters
  always_comb begin
    cur_hs   = line_start ? pnd_hs   : act_hs;
    cur_he   = line_start ? pnd_he   : act_he;
    cur_vs   = line_start ? pnd_vs   : lv_vs;
    cur_ve   = line_start ? pnd_ve   : lv_ve;
    cur_ctrl = line_start ? pnd_ctrl : act_ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_hs   <= '0;
      act_he   <= '0;
      lv_vs    <= '0;
      lv_ve    <= '0;
      act_ctrl <= CTRL_RST;
    end else if (line_start) begin
      act_hs   <= pnd_hs;
      act_he   <= pnd_he;
      lv_vs    <= pnd_vs;
      lv_ve    <= pnd_ve;
      act_ctrl <= pnd_ctrl;
    end
  end
endmodule

// File: rtl/usync_window.sv
module usync_window #(
  parameter int CNT_W = 16
) (
  input  logic             qual,
  input  logic [CNT_W-1:0] lo,
  input  logic [CNT_W-1:0] hi,
  input  logic [CNT_W-1:0] cnt,
  output logic             hit
);
  // lo >= hi yields no count satisfying both bounds, so the window stays idle
  always_comb hit = qual && (cnt >= lo) && (cnt < hi);
endmodule

// File: rtl/usync_combine.sv
module usync_combine
  import usync_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  h_hit,
  input  logic  v_hit,
  input  ctrl_t ctrl,
  output logic  sync_q
);
  logic merged, sync_d;

  always_comb begin
    if (ctrl.op_and)      merged = h_hit & v_hit;
    else if (ctrl.op_or)  merged = h_hit | v_hit;
    else if (ctrl.op_xor) merged = h_hit ^ v_hit;
    else                  merged = 1'b0;
    sync_d = ctrl.pol_inv ? ~merged : merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= CTRL_RST.pol_inv;
    else        sync_q <= sync_d;
  end
endmodule

// File: rtl/usync_gen.sv
module usync_gen
  import usync_pkg::*;
#(
  parameter int PIX_W          = 16,
  parameter int LINE_W         = 15,
  parameter int DATA_W         = 16,
  parameter bit ODD_FIELD_ONLY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix_cnt,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic              field_id,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              usync_o
);
  logic [PIX_W-1:0]  cur_hs, cur_he, act_hs, act_he;
  logic [LINE_W-1:0] cur_vs, cur_ve;
  ctrl_t             cur_ctrl, act_ctrl;
  logic              line_start, v_qual, h_hit, v_hit;

  always_comb line_start = (pix_cnt == '0);

  generate
    if (ODD_FIELD_ONLY) begin : g_vq_odd
      always_comb v_qual = ~field_id;
    end else begin : g_vq_all
      always_comb v_qual = 1'b1;
    end
  endgenerate

  usync_regs #(.PIX_W(PIX_W), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .line_start(line_start),
    .cur_hs(cur_hs), .cur_he(cur_he), .cur_vs(cur_vs), .cur_ve(cur_ve),
    .cur_ctrl(cur_ctrl), .act_hs(act_hs), .act_he(act_he), .act_ctrl(act_ctrl)
  );

  usync_window #(.CNT_W(PIX_W)) u_hwin (
    .qual(1'b1), .lo(cur_hs), .hi(cur_he), .cnt(pix_cnt), .hit(h_hit)
  );

  usync_window #(.CNT_W(LINE_W)) u_vwin (
    .qual(v_qual), .lo(cur_vs), .hi(cur_ve), .cnt(line_cnt), .hit(v_hit)
  );

  usync_combine u_comb (
    .clk(clk), .rst_n(rst_n), .h_hit(h_hit), .v_hit(v_hit),
    .ctrl(cur_ctrl), .sync_q(usync_o)
  );
endmodule

// File: rtl/usync_gen_chk.sv
module usync_gen_chk
  import usync_pkg::*;
#(
  parameter int PIX_W          = 16,
  parameter bit ODD_FIELD_ONLY = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PIX_W-1:0] pix_cnt,
  input logic             field_id,
  input logic             usync_o,
  input logic             h_hit,
  input logic             v_hit,
  input ctrl_t            act_ctrl,
  input logic [PIX_W-1:0] act_hs,
  input logic [PIX_W-1:0] act_he
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // AND with an idle horizontal window leaves the output at its idle level
  assert_and_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && act_ctrl.op_and && !$past(h_hit)) |-> (usync_o == act_ctrl.pol_inv));

  assert_no_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !act_ctrl.op_and && !act_ctrl.op_or && !act_ctrl.op_xor)
      |-> (usync_o == act_ctrl.pol_inv));

  assert_xor_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !act_ctrl.op_and && !act_ctrl.op_or && act_ctrl.op_xor
       && $past(h_hit) && $past(v_hit)) |-> (usync_o == act_ctrl.pol_inv));

  assert_line_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(pix_cnt != '0)) |-> ($stable(act_ctrl) && $stable(act_hs) && $stable(act_he)));

  assert_empty_hwin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && act_ctrl.op_and && (act_hs >= act_he)) |-> (usync_o == act_ctrl.pol_inv));

  assert_even_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ODD_FIELD_ONLY && past_ok && act_ctrl.op_and && $past(field_id))
      |-> (usync_o == act_ctrl.pol_inv));
endmodule

bind usync_gen usync_gen_chk #(.PIX_W(PIX_W), .ODD_FIELD_ONLY(ODD_FIELD_ONLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .field_id(field_id),
  .usync_o(usync_o), .h_hit(h_hit), .v_hit(v_hit), .act_ctrl(act_ctrl),
  .act_hs(act_hs), .act_he(act_he)
);

// File: tb/usync_gen_bench.sv
module usync_gen_bench;
  localparam int LW = 24;   // pixels per line
  localparam int NL = 10;   // lines per field
  localparam int FLD = LW * NL;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pix_cnt;
  logic [14:0] line_cnt;
  logic        field_id;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        usync_o;

  always #2 clk = ~clk;

  usync_gen u_usync_gen (
    .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
    .field_id(field_id), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .usync_o(usync_o)
  );

  int total = 0, bad = 0;
  int p = 0, l = 0, f = 0;
  bit finished = 0;
  string phase = "R1";

  // behavioural model: pending and live settings
  int p_hs, p_he, p_vs, p_ve, a_hs, a_he, a_vs, a_ve;
  bit [3:0] p_ctl, a_ctl;
  bit exp_o;

  function automatic bit model_out(int px, int ln, bit fl);
    bit h, v, m;
    h = (px >= a_hs) && (px < a_he);
    v = (fl == 1'b0) && (ln >= a_vs) && (ln < a_ve);
    if (a_ctl[2])      m = h && v;
    else if (a_ctl[1]) m = h || v;
    else if (a_ctl[0]) m = h ^ v;
    else               m = 1'b0;
    return a_ctl[3] ? !m : m;
  endfunction

  function automatic string op_tag();
    string s;
    if (a_ctl[2])      s = "R5";
    else if (a_ctl[1]) s = "R6";
    else if (a_ctl[0]) s = "R7";
    else               s = "R8";
    return {s, a_ctl[3] ? " R9-low" : " R9-high"};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      p_hs = 0; p_he = 0; p_vs = 0; p_ve = 0; p_ctl = 4'b1000;
      a_hs = 0; a_he = 0; a_vs = 0; a_ve = 0; a_ctl = 4'b1000;
      exp_o = 1'b1;
    end else begin
      if (pix_cnt == 0) begin
        a_hs = p_hs; a_he = p_he; a_vs = p_vs; a_ve = p_ve; a_ctl = p_ctl;
      end
      exp_o = model_out(pix_cnt, line_cnt, field_id);
      if (wr_en) begin
        case (wr_addr)
          3'd0: p_hs  = wr_data;
          3'd1: p_he  = wr_data;
          3'd2: p_vs  = wr_data[14:0];
          3'd3: p_ve  = wr_data[14:0];
          3'd4: p_ctl = wr_data[3:0];
          default: ;
        endcase
      end
    end
  end

  // R10: every cycle the registered output is compared one edge after sampling
  task automatic check_out();
    total++;
    if (usync_o !== exp_o) begin
      bad++;
      $display("FAIL %s R10 [%s] pix=%0d line=%0d fld=%0d got=%b exp=%b",
               phase, op_tag(), pix_cnt, line_cnt, field_id, usync_o, exp_o);
    end
  endtask

  task automatic step(bit we, int a, int d);
    @(negedge clk);
    check_out();
    wr_en    = we;
    wr_addr  = a[2:0];
    wr_data  = d[15:0];
    pix_cnt  = p[15:0];
    line_cnt = l[14:0];
    field_id = f[0];
    p++;
    if (p == LW) begin
      p = 0; l++;
      if (l == NL) begin l = 0; f ^= 1; end
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic prog(int a, int d);
    step(1, a, d);
  endtask

  initial begin
    rst_n = 1'b0; pix_cnt = '0; line_cnt = '0; field_id = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    total++;
    if (usync_o !== 1'b1) begin
      bad++;
      $display("FAIL R1 reset level got=%b exp=1", usync_o);
    end
    rst_n = 1'b1;
    phase = "R1";
    run(FLD);

    phase = "R2 R3";
    prog(0, 5); prog(1, 15); prog(2, 2); prog(3, 7);
    for (int pol = 1; pol >= 0; pol--) begin
      for (int k = 0; k < 8; k++) begin
        prog(4, (pol << 3) | k);
        run(2 * FLD);
      end
    end

    phase = "R2 edges";
    prog(4, 4'b0010); prog(0, 0); prog(1, LW);
    run(2 * FLD);

    phase = "R4";
    prog(0, 15); prog(1, 5);
    run(2 * FLD);
    prog(0, 5); prog(1, 15); prog(2, 4); prog(3, 4);
    run(2 * FLD);
    prog(4, 4'b1001);
    run(2 * FLD);

    phase = "R12";
    prog(2, 2); prog(3, 16'h8007); prog(4, 16'hFFF4);
    run(2 * FLD);
    prog(5, 16'hFFFF); prog(6, 16'h0000); prog(7, 16'h00FF);
    run(2 * FLD);

    phase = "R11";
    prog(4, 4'b1001);
    for (int k = 0; k < 30; k++) begin
      run(7 + (k % 5));
      prog(k % 2, (k * 3) % 26);
    end
    run(2 * FLD);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule